// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a vector of interrupt inputs and drives one active-low request line toward a processor. Each input has its own priority and trigger mode. Software enables inputs with separate set and clear registers. It reads an acknowledge register to learn which input won, and writes an end-of-service register once the handler is done.

Between those two accesses the block keeps a hardware stack of the priority levels being serviced. It raises the request line only when an enabled pending input outranks the level on top of that stack. A handler can therefore be preempted by strictly more urgent work. When the handler finishes and the stack pops, inputs waiting at lower levels are compared against the level that was restored.

The register map is word addressed with a 6-bit address. A read has its side effect on the clock edge at which `bus_rd` is sampled high. `bus_rdata` is combinational from `bus_addr`. If `bus_wr` and `bus_rd` are both high, the write is performed and the read has no side effect.

Top module: `npic_top`

## Requirements
- R1: After reset the request line is high, the stack is empty, the error flag is clear, and every enable bit and every configuration field reads as zero.
- R2: A write to address 0x20 sets the enable bits that are 1 in the data. A write to 0x21 clears the enable bits that are 1 in the data. A read at either address returns the enable mask.
- R3: A disabled input never pulls the request line low and is never returned by an acknowledge read, even when it is pending with the highest priority.
- R4: When the stack is empty, any pending enabled input pulls the request line low, whatever its priority.
- R5: A read of address 0x22 returns bit 31 set and the winning input index in bits [4:0]. The winner is the pending enabled input with the highest priority, and a tie goes to the lowest index. With no such input the read returns 0 and pushes nothing.
- R6: A successful acknowledge pushes the winner's priority, which becomes the current level (status bits [6:4]), and increments the depth (status bits [11:8]). The status register is at address 0x24.
- R7: While the stack is not empty, the request line goes low only for a pending enabled input whose priority is strictly above the current level.
- R8: A write of any value to address 0x23 pops the stack and restores the previous level. The request line goes low again if a pending input outranks the restored level.
- R9: A level-mode input is pending exactly while its input is high. If it is still high when the end-of-service write pops the stack, it competes again.
- R10: Configuration word i (addresses 0x00 to 0x1F) holds the priority in bits [2:0] and the trigger mode in bit 4 (1 = edge). An edge-mode input is set pending by a rising edge and cleared by its acknowledge, and a steady high input does not set it again. Pending bits read at 0x25.
- R11: With 8 entries, a push onto a full stack or a pop from an empty stack leaves the stack unchanged and sets a sticky error flag (status bit 0). Writing 1 to status bit 0 clears the flag.
- R12: The request line is registered. It changes on the first clock edge after the pending bits, enables or stack change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Interrupt inputs, synchronous to clk |
| bus_addr | input | 6 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: 32 inputs and 3-bit priorities, which gives eight levels and an eight-entry stack. With that depth, eight acknowledges of one held level input fill the stack, so the overflow and underflow paths of the error flag can be reached in a short directed sequence. With 32 inputs, the tie-break and masking checks can use widely spaced indices against the full enable word.

// File: rtl/npic_pkg.sv
// Shared constants for the nested priority interrupt controller.
// Assumes a 6-bit word address; configuration words occupy 0x00-0x1F.
package npic_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_EN_SET = 6'h20;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 6'h21;
    localparam logic [ADDR_W-1:0] A_ACK    = 6'h22;
    localparam logic [ADDR_W-1:0] A_EOI    = 6'h23;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'h24;
    localparam logic [ADDR_W-1:0] A_PEND   = 6'h25;

    // Bit position of the trigger mode inside a configuration word
    localparam int CFG_TRIG_BIT = 4;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;
endpackage

// File: rtl/npic_regs.sv
// Register file: per-input priority and trigger mode, enable mask, and
// decode of the side-effect strobes (acknowledge, end-of-service, error clear).
// Assumes N_SRC <= 32 and PRIO_W <= 4 so that one config word fits the map.
module npic_regs
    import npic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic [N_SRC-1:0]        trig_mode,
    output logic [N_SRC-1:0]        enable,
    output logic                    ack_stb,
    output logic                    eoi_stb,
    output logic                    err_clr_stb
);
    logic cfg_wr;

    // Decode of accesses that act on the clock edge
    always_comb begin
        cfg_wr      = bus_wr && !bus_addr[ADDR_W-1];
        ack_stb     = bus_rd && !bus_wr && (bus_addr == A_ACK);
        eoi_stb     = bus_wr && (bus_addr == A_EOI);
        err_clr_stb = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];
    end

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_cfg
        logic [PRIO_W-1:0] prio_q;
        trig_e             trig_q;

        // Per-input configuration word storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                trig_q <= TRIG_LEVEL;
            end else if (cfg_wr && (bus_addr[4:0] == 5'(gi))) begin
                prio_q <= bus_wdata[PRIO_W-1:0];
                trig_q <= trig_e'(bus_wdata[CFG_TRIG_BIT]);
            end
        end

        assign prio_flat[gi*PRIO_W +: PRIO_W] = prio_q;
        assign trig_mode[gi]                  = (trig_q == TRIG_EDGE);
    end

    // Enable mask with write-1-to-set and write-1-to-clear ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (bus_wr && (bus_addr == A_EN_SET)) begin
            enable <= enable | bus_wdata[N_SRC-1:0];
        end else if (bus_wr && (bus_addr == A_EN_CLR)) begin
            enable <= enable & ~bus_wdata[N_SRC-1:0];
        end
    end
endmodule

// File: rtl/npic_pending.sv
// Pending state per input: edge-mode inputs latch a rising edge until
// acknowledged; level-mode inputs follow the input directly.
// Assumes src_in is already synchronous to clk.
module npic_pending #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] trig_mode,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] pending
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] edge_q;
    logic [N_SRC-1:0] rise;

    // Rising-edge detection against the previous sample
    always_comb rise = src_in & ~prev_q;

    // Edge latch: a new edge wins over a same-cycle acknowledge clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            edge_q <= '0;
        end else begin
            prev_q <= src_in;
            edge_q <= ((edge_q & ~ack_clr) | rise) & trig_mode;
        end
    end

    // Mode select between latched edge and live level
    always_comb pending = (trig_mode & edge_q) | (~trig_mode & src_in);
endmodule

// File: rtl/npic_arbiter.sv
// Picks the pending enabled input with the highest priority; a tie goes to
// the lowest index. Purely combinational.
module npic_arbiter #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        pending,
    input  logic [N_SRC-1:0]        enable,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx,
    output logic [PRIO_W-1:0]       win_prio
);
    // Linear scan; strict compare keeps the earliest index on ties
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pending[i] && enable[i]) begin
                if (!win_valid || (prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                    win_valid = 1'b1;
                    win_idx   = IDX_W'(i);
                    win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end
endmodule

// File: rtl/npic_stack.sv
// Stack of serviced priority levels. A push when full or a pop when empty
// changes nothing and sets a sticky error flag. Assumes push and pop are
// never requested in the same cycle.
module npic_stack #(
    parameter int PRIO_W = 3,
    localparam int DEPTH = 1 << PRIO_W,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  depth,
    output logic [PRIO_W-1:0] cur_lvl,
    output logic              empty,
    output logic              full,
    output logic              err
);
    logic [PRIO_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  top_ptr;
    logic [PTR_W-1:0]  wr_ptr;

    // Occupancy flags and pointers
    always_comb begin
        empty   = (depth == '0);
        full    = (depth == CNT_W'(DEPTH));
        top_ptr = PTR_W'(depth - 1'b1);
        wr_ptr  = PTR_W'(depth);
        cur_lvl = empty ? '0 : mem[top_ptr];
    end

    // Push, pop and error tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            err   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (err_clr) err <= 1'b0;
            if (push) begin
                if (full) begin
                    err <= 1'b1;
                end else begin
                    mem[wr_ptr] <= push_lvl;
                    depth       <= depth + 1'b1;
                end
            end else if (pop) begin
                if (empty) err   <= 1'b1;
                else       depth <= depth - 1'b1;
            end
        end
    end
endmodule

// File: rtl/npic_top.sv
// Nested priority interrupt controller top: ties the register file, pending
// logic, arbiter and level stack together, registers the request line and
// drives the read-data mux. Assumes N_SRC <= 32 and PRIO_W <= 4.
module npic_top
    import npic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int DEPTH = 1 << PRIO_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic [N_SRC-1:0]        trig_mode;
    logic [N_SRC-1:0]        enable;
    logic [N_SRC-1:0]        pending;
    logic [N_SRC-1:0]        ack_clr;
    logic                    ack_stb;
    logic                    eoi_stb;
    logic                    err_clr_stb;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic [PRIO_W-1:0]       win_prio;
    logic [CNT_W-1:0]        depth;
    logic [PRIO_W-1:0]       cur_lvl;
    logic                    empty;
    logic                    full;
    logic                    err;
    logic                    push_req;
    logic                    req;

    npic_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .prio_flat(prio_flat), .trig_mode(trig_mode), .enable(enable),
        .ack_stb(ack_stb), .eoi_stb(eoi_stb), .err_clr_stb(err_clr_stb)
    );

    npic_pending #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .trig_mode(trig_mode),
        .ack_clr(ack_clr), .pending(pending)
    );

    npic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .pending(pending), .enable(enable), .prio_flat(prio_flat),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    npic_stack #(.PRIO_W(PRIO_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push_req), .pop(eoi_stb),
        .push_lvl(win_prio), .err_clr(err_clr_stb),
        .depth(depth), .cur_lvl(cur_lvl), .empty(empty), .full(full), .err(err)
    );

    // Acknowledge push request and edge-pending clear (skipped when full)
    always_comb begin
        push_req = ack_stb && win_valid;
        ack_clr  = '0;
        if (push_req && !full) ack_clr[win_idx] = 1'b1;
    end

    // Request condition: winner outranks the serviced level, or nothing is serviced
    always_comb req = win_valid && (empty || (win_prio > cur_lvl));

    // Registered active-low request line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= !req;
    end

    // Read-data mux
    always_comb begin
        int ci;
        ci        = int'(bus_addr[4:0]);
        bus_rdata = '0;
        if (!bus_addr[ADDR_W-1]) begin
            if (ci < N_SRC) begin
                bus_rdata[PRIO_W-1:0]   = prio_flat[ci*PRIO_W +: PRIO_W];
                bus_rdata[CFG_TRIG_BIT] = trig_mode[ci];
            end
        end else begin
            case (bus_addr)
                A_EN_SET, A_EN_CLR: bus_rdata[N_SRC-1:0] = enable;
                A_ACK: begin
                    bus_rdata[DATA_W-1]  = win_valid;
                    bus_rdata[IDX_W-1:0] = win_idx;
                end
                A_STAT: begin
                    bus_rdata[0]           = err;
                    bus_rdata[4 +: PRIO_W] = cur_lvl;
                    bus_rdata[8 +: CNT_W]  = depth;
                end
                A_PEND:  bus_rdata[N_SRC-1:0] = pending;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/npic_checker.sv
// Assertion checker for npic_top, attached with the bind below. Observes the
// stack, arbiter and decode signals and the registered request line.
module npic_checker #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int DEPTH = 1 << PRIO_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic [N_SRC-1:0]  enable,
    input logic [N_SRC-1:0]  pending,
    input logic              ack_stb,
    input logic              eoi_stb,
    input logic              err_clr_stb,
    input logic              win_valid,
    input logic [IDX_W-1:0]  win_idx,
    input logic [PRIO_W-1:0] win_prio,
    input logic [CNT_W-1:0]  depth,
    input logic [PRIO_W-1:0] cur_lvl,
    input logic              err
);
    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH)); // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && win_valid && depth == CNT_W'(DEPTH)) |=> (depth == CNT_W'(DEPTH)) && err); // R11

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && depth == '0) |=> (depth == '0) && err); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr_stb) |=> err); // R11

    AST_PUSH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && win_valid && depth < CNT_W'(DEPTH))
        |=> (depth == $past(depth) + 1'b1) && (cur_lvl == $past(win_prio))); // R6

    AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && depth != '0) |=> (depth == $past(depth) - 1'b1)); // R8

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> irq_n); // R3

    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (enable[win_idx] && pending[win_idx])); // R5
endmodule

bind npic_top npic_checker #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .enable(enable), .pending(pending),
    .ack_stb(ack_stb), .eoi_stb(eoi_stb), .err_clr_stb(err_clr_stb),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio),
    .depth(depth), .cur_lvl(cur_lvl), .err(err)
);

// File: tb/npic_top_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; each task checks its own results.
module npic_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;
    int          total = 0;
    int          bad = 0;

    npic_top u_npic_top (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        src_in = '0;
        rst_n  = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg(input int idx, input int prio, input bit edge_m);
        wr(6'(idx), {27'd0, edge_m, 1'b0, 3'(prio)});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 irq_n", {31'd0, irq_n}, 32'd1);
        rd(6'h24, d); check("R1 status", d, 32'h0);
        rd(6'h20, d); check("R1 enable", d, 32'h0);
        rd(6'h07, d); check("R1 config", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        do_reset();
        wr(6'h20, 32'hF0F0_0001);
        rd(6'h20, d); check("R2 set", d, 32'hF0F0_0001);
        wr(6'h21, 32'h0000_00F1);
        rd(6'h21, d); check("R2 clear", d, 32'hF0F0_0000);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        cfg(5, 7, 1'b0);
        src_in[5] = 1'b1;
        wait_cyc(2);
        check("R3 quiet", {31'd0, irq_n}, 32'd1);
        rd(6'h22, d); check("R5 none", d, 32'h0);
        rd(6'h24, d); check("R5 no push", d, 32'h0);
        cfg(6, 0, 1'b0);
        wr(6'h20, 32'h40);
        src_in[6] = 1'b1;
        wait_cyc(2);
        rd(6'h22, d); check("R3 skip disabled", d, 32'h8000_0006);
    endtask

    task automatic t_empty_timing();
        do_reset();
        cfg(9, 0, 1'b0);
        wr(6'h20, 32'h200);
        wait_cyc(1);
        src_in[9] = 1'b1;
        #1 check("R12 not yet", {31'd0, irq_n}, 32'd1);
        @(negedge clk);
        check("R4 R12 asserted", {31'd0, irq_n}, 32'd0);
    endtask

    task automatic t_tie_preempt();
        logic [31:0] d;
        do_reset();
        cfg(3, 2, 1'b0); cfg(9, 2, 1'b0);
        wr(6'h20, 32'h208);
        src_in[3] = 1'b1; src_in[9] = 1'b1;
        wait_cyc(2);
        rd(6'h22, d); check("R5 tie low index", d, 32'h8000_0003);
        wait_cyc(1);
        rd(6'h24, d); check("R6 pushed", d, 32'h120);
        check("R7 equal no req", {31'd0, irq_n}, 32'd1);
        cfg(12, 5, 1'b0);
        wr(6'h20, 32'h1000);
        src_in[12] = 1'b1;
        wait_cyc(2);
        check("R7 preempt", {31'd0, irq_n}, 32'd0);
        rd(6'h22, d); check("R5 preempt idx", d, 32'h8000_000C);
        wait_cyc(1);
        rd(6'h24, d); check("R6 nested", d, 32'h250);
        check("R6 deasserted", {31'd0, irq_n}, 32'd1);
        src_in[12] = 1'b0;
        wr(6'h23, 32'h0);
        wait_cyc(1);
        rd(6'h24, d); check("R8 restored", d, 32'h120);
        check("R8 equal stays quiet", {31'd0, irq_n}, 32'd1);
    endtask

    task automatic t_refire();
        logic [31:0] d;
        do_reset();
        cfg(2, 1, 1'b0); cfg(7, 6, 1'b0); cfg(4, 4, 1'b0);
        wr(6'h20, 32'h94);
        src_in[2] = 1'b1;
        wait_cyc(2);
        rd(6'h22, d); check("R5 first", d, 32'h8000_0002);
        src_in[7] = 1'b1;
        wait_cyc(2);
        check("R7 higher asserts", {31'd0, irq_n}, 32'd0);
        rd(6'h22, d); check("R5 second", d, 32'h8000_0007);
        src_in[4] = 1'b1;
        wait_cyc(2);
        check("R7 lower held off", {31'd0, irq_n}, 32'd1);
        src_in[7] = 1'b0;
        wr(6'h23, 32'h0);
        wait_cyc(1);
        check("R8 refire", {31'd0, irq_n}, 32'd0);
        rd(6'h24, d); check("R8 level back", d, 32'h110);
        rd(6'h22, d); check("R8 waiting wins", d, 32'h8000_0004);
    endtask

    task automatic t_level_stays();
        logic [31:0] d;
        do_reset();
        cfg(2, 1, 1'b0); cfg(7, 6, 1'b0);
        wr(6'h20, 32'h84);
        src_in[2] = 1'b1;
        wait_cyc(2);
        rd(6'h22, d);
        src_in[7] = 1'b1;
        wait_cyc(2);
        rd(6'h22, d); check("R9 ack", d, 32'h8000_0007);
        wr(6'h23, 32'h0);
        wait_cyc(1);
        check("R9 uncleared again", {31'd0, irq_n}, 32'd0);
        rd(6'h22, d); check("R9 returned again", d, 32'h8000_0007);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        cfg(20, 3, 1'b1);
        wr(6'h20, 32'h0010_0000);
        rd(6'h14, d); check("R10 config", d, 32'h13);
        src_in[20] = 1'b1;
        @(negedge clk);
        src_in[20] = 1'b0;
        wait_cyc(1);
        rd(6'h25, d); check("R10 latched", d, 32'h0010_0000);
        check("R10 request", {31'd0, irq_n}, 32'd0);
        rd(6'h22, d); check("R10 ack", d, 32'h8000_0014);
        rd(6'h25, d); check("R10 cleared", d, 32'h0);
        src_in[20] = 1'b1;
        wait_cyc(2);
        rd(6'h22, d); check("R10 second edge", d, 32'h8000_0014);
        wait_cyc(3);
        rd(6'h25, d); check("R10 steady high", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        do_reset();
        wr(6'h23, 32'h0);
        rd(6'h24, d); check("R11 underflow", d, 32'h1);
        wr(6'h24, 32'h1);
        rd(6'h24, d); check("R11 clear", d, 32'h0);
        cfg(1, 3, 1'b0);
        wr(6'h20, 32'h2);
        src_in[1] = 1'b1;
        wait_cyc(1);
        for (int k = 0; k < 8; k++) rd(6'h22, d);
        rd(6'h24, d); check("R11 full", d, 32'h830);
        rd(6'h22, d);
        rd(6'h24, d); check("R11 overflow", d, 32'h831);
        wr(6'h24, 32'h1);
        for (int k = 0; k < 8; k++) wr(6'h23, 32'h0);
        rd(6'h24, d); check("R11 drained", d, 32'h0);
        wait_cyc(1);
        check("R4 empty again", {31'd0, irq_n}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_mask();
        t_empty_timing();
        t_tie_preempt();
        t_refire();
        t_level_stays();
        t_edge();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule